// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout

This block supervises software. It counts slow ticks, and software must refresh it before the count reaches the chosen limit. If software does not, the block raises a reset pulse for the rest of the system. A two-bit select field picks one of four limits. The limits are one, two, four and sixteen times a base tick count, so the largest step is four times the one below it rather than two.

The block also times the power-on delay. After the power-on reset input is released, it counts a fixed number of ticks and then raises a done flag. The watchdog does not count before that flag is high. The tick is a one-cycle strobe taken from a slower time base elsewhere on the chip.

A mode bit sets what happens in stop mode: the count either freezes or keeps running. A new select value written to the mode register waits until the next refresh before it applies, so an interval already in progress is never cut short. When the watchdog expires, the mode register returns to its defaults.

Top module: `wdog_timer`

## Requirements
- R1: While `rstN` is low and right after it is released, `wdtRst` and `porDone` are 0. The mode register then holds select 00 and stop-run 0.
- R2: `porDone` goes to 1 on the edge of the POR_TICKS-th tick after `rstN` is released, and then stays at 1. Ticks before that edge do not advance the watchdog count.
- R3: The select field is `cfgData[1:0]`. Once it is in force, the watchdog expires on the tick numbered BASE_TICKS×{1,2,4,16} after the last refresh, for select 00, 01, 10 and 11. No earlier tick causes an expiry.
- R4: A refresh clears the count. A refresh in the same cycle as the tick that would expire wins, and no reset follows.
- R5: A select written with `cfgWr` takes effect only at the next refresh. The interval already running keeps its old limit.
- R6: `wdtRst` goes high in the cycle after the expiring tick's edge and stays high for exactly PULSE_CYCLES consecutive cycles.
- R7: Expiry restores the defaults: select 00 in force and stop-run 0.
- R8: While `stopIn` is 1 and stop-run (`cfgData[2]`) is 0, ticks are ignored and the count holds. Counting resumes from that value when `stopIn` returns to 0.
- R9: While stop-run is 1, the watchdog keeps counting with `stopIn` at 1 and expires as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| tickIn | input | 1 | One-cycle slow time-base strobe |
| refreshIn | input | 1 | Software refresh strobe |
| cfgWr | input | 1 | Mode register write enable |
| cfgData | input | 3 | [1:0] timeout select, [2] keep running in stop mode |
| stopIn | input | 1 | Device is in stop mode |
| wdtRst | output | 1 | Watchdog reset pulse |
| porDone | output | 1 | Power-on delay has elapsed |

## Verification
Each input is registered in one stage, so the tick, refresh or write that drives a change shows its effect at the clock edge that samples it. The bench drives every strobe for one cycle starting at a falling edge. It samples at the next falling edge, where `porDone` and the start of the `wdtRst` pulse become visible. The bench counts ticks against the limit computed from the requirement. It checks that `wdtRst` stays 0 on every tick before the last one and is 1 just after the last one. It then counts the falling edges at which the pulse is still high.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic cntInc;   // advance the tick count
    logic cntClear; // refresh: clear count, load pending select
    logic expire;   // timeout: clear count, restore mode defaults
  } wdogStrobe_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdogStrobe_t      strobe,
  input  logic             cfgWr,
  input  logic [SEL_W:0]   cfgData,
  output logic             atLimit,
  output logic             runInStop
);
  localparam int MAX_TICKS = BASE_TICKS * 16;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [SEL_W-1:0] modeSel;
  logic [SEL_W-1:0] activeSel;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;

  // Mode register and the select in force
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSel   <= '0;
      runInStop <= 1'b0;
      activeSel <= '0;
    end else if (strobe.expire) begin
      modeSel   <= '0;
      runInStop <= 1'b0;
      activeSel <= '0;
    end else begin
      if (cfgWr) begin
        modeSel   <= cfgData[SEL_W-1:0];
        runInStop <= cfgData[SEL_W];
      end
      if (strobe.cntClear) activeSel <= modeSel;
    end
  end

  // Scaled limit: 1x, 2x, 4x, 16x of the base
  always_comb begin
    unique case (activeSel)
      2'd0:    limit = CNT_W'(BASE_TICKS);
      2'd1:    limit = CNT_W'(BASE_TICKS * 2);
      2'd2:    limit = CNT_W'(BASE_TICKS * 4);
      default: limit = CNT_W'(BASE_TICKS * 16);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  count <= '0;
    else if (strobe.expire || strobe.cntClear)  count <= '0;
    else if (strobe.cntInc)                     count <= count + 1'b1;
  end

  assign atLimit = (count == limit - 1'b1);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int POR_TICKS    = 32,
  parameter int PULSE_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickIn,
  input  logic        refreshIn,
  input  logic        stopIn,
  input  logic        runInStop,
  input  logic        atLimit,
  output wdogStrobe_t strobe,
  output logic        wdtRst,
  output logic        porDone
);
  localparam int POR_W = $clog2(POR_TICKS + 1);
  localparam int PUL_W = $clog2(PULSE_CYCLES + 1);

  logic [POR_W-1:0] porCnt;
  logic [PUL_W-1:0] pulseCnt;
  logic             pulseActive;
  logic             running;

  assign pulseActive = (pulseCnt != '0);
  assign running     = porDone && !pulseActive && (!stopIn || runInStop);

  always_comb begin
    strobe          = '0;
    strobe.cntClear = refreshIn;
    strobe.expire   = running && tickIn && atLimit && !refreshIn;
    strobe.cntInc   = running && tickIn && !atLimit && !refreshIn;
  end

  // Power-on delay in ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      porCnt  <= '0;
      porDone <= 1'b0;
    end else if (!porDone && tickIn) begin
      if (porCnt == POR_W'(POR_TICKS - 1)) porDone <= 1'b1;
      else                                 porCnt  <= porCnt + 1'b1;
    end
  end

  // Fixed-length reset pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pulseCnt <= '0;
    else if (strobe.expire) pulseCnt <= PUL_W'(PULSE_CYCLES);
    else if (pulseActive)   pulseCnt <= pulseCnt - 1'b1;
  end

  assign wdtRst = pulseActive;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS   = 16,
  parameter int POR_TICKS    = 32,
  parameter int PULSE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       refreshIn,
  input  logic       cfgWr,
  input  logic [2:0] cfgData,
  input  logic       stopIn,
  output logic       wdtRst,
  output logic       porDone
);
  wdogStrobe_t strobe;
  logic        atLimit;
  logic        runInStop;

  wdog_ctrl #(.POR_TICKS(POR_TICKS), .PULSE_CYCLES(PULSE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .refreshIn(refreshIn),
    .stopIn(stopIn), .runInStop(runInStop), .atLimit(atLimit),
    .strobe(strobe), .wdtRst(wdtRst), .porDone(porDone)
  );

  wdog_datapath #(.BASE_TICKS(BASE_TICKS), .SEL_W(2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWr(cfgWr),
    .cfgData(cfgData), .atLimit(atLimit), .runInStop(runInStop)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int PULSE_CYCLES = 16
) (
  input logic clk,
  input logic rstN,
  input logic tickIn,
  input logic refreshIn,
  input logic wdtRst,
  input logic porDone
);
  logic [7:0] hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       hiCnt <= '0;
    else if (wdtRst) hiCnt <= hiCnt + 1'b1;
    else             hiCnt <= '0;
  end

  // R2
  por_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    porDone |=> porDone);

  // R2
  no_rst_before_por_chk: assert property (@(posedge clk) disable iff (!rstN)
    !porDone |-> !wdtRst);

  // R3
  rst_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdtRst) |-> $past(tickIn));

  // R4
  refresh_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshIn |=> !$rose(wdtRst));

  // R6
  pulse_not_long_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |-> (hiCnt < 8'(PULSE_CYCLES)));

  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdtRst) |-> (hiCnt == 8'(PULSE_CYCLES)));
endmodule

bind wdog_timer wdog_timer_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .tickIn(tickIn), .refreshIn(refreshIn),
  .wdtRst(wdtRst), .porDone(porDone)
);

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;
  localparam int BASE  = 4;
  localparam int POR   = 6;
  localparam int PULSE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0, refreshIn = 1'b0, cfgWr = 1'b0, stopIn = 1'b0;
  logic [2:0] cfgData = 3'd0;
  logic wdtRst, porDone;
  int checks = 0, fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  wdog_timer #(.BASE_TICKS(BASE), .POR_TICKS(POR), .PULSE_CYCLES(PULSE)) u_dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .refreshIn(refreshIn),
    .cfgWr(cfgWr), .cfgData(cfgData), .stopIn(stopIn),
    .wdtRst(wdtRst), .porDone(porDone)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doTick();
    @(negedge clk) tickIn = 1'b1;
    @(negedge clk) tickIn = 1'b0;
  endtask

  task automatic doRefresh();
    @(negedge clk) refreshIn = 1'b1;
    @(negedge clk) refreshIn = 1'b0;
  endtask

  task automatic writeMode(input logic [2:0] d);
    @(negedge clk) begin cfgWr = 1'b1; cfgData = d; end
    @(negedge clk) cfgWr = 1'b0;
  endtask

  // n ticks; no reset on the first n-1, reset right after the n-th
  task automatic ticksToExpire(input int n, input string req);
    for (int i = 1; i < n; i++) begin
      doTick();
      if (wdtRst) check(1'b0, req, i, 0);
    end
    doTick();
    check(wdtRst == 1'b1, req, wdtRst, 1);
  endtask

  // count the remaining pulse, already high at this sample point
  task automatic measurePulse(input string req);
    int len = 0;
    while (wdtRst && len < 100) begin
      len++;
      @(negedge clk);
    end
    check(len == PULSE, req, len, PULSE);
  endtask

  task automatic testReset();
    #1;
    check(wdtRst == 1'b0 && porDone == 1'b0, "R1 in reset", {wdtRst, porDone}, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(wdtRst == 1'b0 && porDone == 1'b0, "R1 after release", {wdtRst, porDone}, 0);
  endtask

  task automatic testPor();
    doRefresh();
    for (int i = 1; i < POR; i++) begin
      doTick();
      if (porDone || wdtRst) check(1'b0, "R2 early", i, 0);
    end
    doTick();
    check(porDone == 1'b1, "R2 porDone", porDone, 1);
    // ticks before porDone did not count; default select 00 (R1)
    ticksToExpire(BASE, "R2 R1 count after por");
    measurePulse("R6 pulse length");
    check(porDone == 1'b1, "R2 sticky", porDone, 1);
  endtask

  task automatic testSelects();
    writeMode(3'b001); doRefresh(); ticksToExpire(BASE * 2, "R3 sel01"); measurePulse("R6");
    writeMode(3'b010); doRefresh(); ticksToExpire(BASE * 4, "R3 sel10"); measurePulse("R6");
    writeMode(3'b011); doRefresh(); ticksToExpire(BASE * 16, "R3 sel11"); measurePulse("R6");
    // R7: after expiry the select in force is 00 again
    doRefresh(); ticksToExpire(BASE, "R7 default select"); measurePulse("R6");
  endtask

  task automatic testDeferred();
    doRefresh();
    writeMode(3'b011);
    ticksToExpire(BASE, "R5 old limit kept");
    measurePulse("R6");
  endtask

  task automatic testRefreshPriority();
    doRefresh();
    for (int i = 1; i < BASE; i++) doTick();
    @(negedge clk) begin tickIn = 1'b1; refreshIn = 1'b1; end
    @(negedge clk) begin tickIn = 1'b0; refreshIn = 1'b0; end
    check(wdtRst == 1'b0, "R4 refresh beats expiry", wdtRst, 0);
    ticksToExpire(BASE, "R4 count restarted");
    measurePulse("R6");
  endtask

  task automatic testStopHalt();
    doRefresh();
    doTick(); doTick();
    stopIn = 1'b1;
    for (int i = 0; i < 10; i++) doTick();
    check(wdtRst == 1'b0, "R8 halted in stop", wdtRst, 0);
    stopIn = 1'b0;
    ticksToExpire(BASE - 2, "R8 resumes from held count");
    measurePulse("R6");
  endtask

  task automatic testStopRun();
    writeMode(3'b100);
    doRefresh();
    stopIn = 1'b1;
    ticksToExpire(BASE, "R9 runs in stop");
    measurePulse("R6");
    // R7: stop-run bit cleared by expiry
    doRefresh();
    for (int i = 0; i < BASE + 2; i++) doTick();
    check(wdtRst == 1'b0, "R7 stop-run default", wdtRst, 0);
    stopIn = 1'b0;
    doRefresh();
  endtask

  initial begin
    testReset();
    testPor();
    testSelects();
    testDeferred();
    testRefreshPriority();
    testStopHalt();
    testStopRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule